// File: doc/BRIEF.md
# Clock Recovery Training Controller

This block runs the clock-recovery phase of a link of up to two lanes. A `start` pulse latches the lane count and loads a default drive byte (voltage swing 2, no pre-emphasis) into every active lane. That set is written to the sink. The block then loops. It waits a programmable number of cycles and requests the lane status bytes. If every active lane reports lock, the phase passes. If not, it builds a new drive byte per lane from the levels the sink asked for and writes the full set back.

Two limits end a phase that never locks. A same-setting counter starts at 1, returns to 1 whenever the requested drive set changes, and increments otherwise. A read that sees the counter at 5 without lock ends the phase as a failure. Separately, the phase fails once 80 adjustment iterations have completed. A response whose byte count differs from the request aborts the phase with an error.

All sink traffic goes through one request channel and one response channel, each using valid/ready. Back-pressure rules: a raised request holds its kind, length and data unchanged until `req_ready` accepts it. A response is consumed only in a cycle where `rsp_ready` is high. The sink may hold `rsp_valid` for as long as it likes before that.

Top module: `cr_train_ctrl`

## Requirements
- R1: After reset, `done`, `result`, `req_valid` and `rsp_ready` are all 0.
- R2: After `start`, the first request is a write (`req_write`=1) with `req_len` equal to the lane count. Lane L's drive byte is carried in `req_data[8L+7:8L]`. Active lanes carry 8'h02 and inactive lanes carry 8'h00.
- R3: After each write response is accepted, exactly `wait_cycles`+1 cycles pass with no request. Then a status read (`req_write`=0, `req_len`=2) is raised.
- R4: Bit 0 of a lane's status byte is its lock flag. The phase passes as soon as a read shows lock on every active lane. Lock flags of inactive lanes are ignored.
- R5: Status bits [2:1] give the requested swing and bits [4:3] the requested pre-emphasis. The new drive byte is {4'b0, pre-emphasis, swing} for active lanes and 0 for inactive lanes. It is written after every unlocked read, even when it is unchanged.
- R6: The same-setting counter starts at 1. It resets to 1 when the new set differs from the stored one and increments otherwise. An unlocked read taken while the counter is 5 fails the phase. Lock on that same read passes instead.
- R7: The write response that completes the 80th adjustment iteration fails the phase.
- R8: A response whose `rsp_len` differs from the requested length ends the phase with an error. No further request follows.
- R9: `done` is a one-cycle pulse in the cycle after the final response is accepted. At that pulse `result` is 1 for pass, 2 for fail and 3 for error. At all other times `result` is 0.
- R10: A request stays stable while `req_valid` is high and `req_ready` is low. `rsp_ready` is high only while a response is awaited, and never in the same cycle as `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a phase (sampled while idle) |
| lane_cnt | input | 2 | Active lanes, 1 or 2 |
| wait_cycles | input | 16 | Delay before each status read |
| req_valid | output | 1 | Request to the sink is valid |
| req_ready | input | 1 | Sink accepts the request |
| req_write | output | 1 | 1 = drive write, 0 = status read |
| req_len | output | 2 | Bytes to transfer |
| req_data | output | 16 | Drive bytes, lane L in bits [8L+7:8L] |
| rsp_valid | input | 1 | Response from the sink is valid |
| rsp_ready | output | 1 | Block can take the response |
| rsp_len | input | 2 | Bytes actually transferred |
| rsp_data | input | 16 | Status bytes, lane L in bits [8L+7:8L] |
| done | output | 1 | Phase finished (one cycle) |
| result | output | 2 | 1 pass, 2 fail, 3 error |

## Verification
The lock check and the same-setting limit both act on one status read. The bench provokes the collision by returning an unchanged request four times and then a status with every lane locked. The reference model expects a pass, because lock is evaluated ahead of the counter limit. A neighbouring run sends a changed request in the middle of a run of unchanged ones, which shows the counter reset moving the failure point. A short response is also placed on a read that might otherwise have reached a verdict, and that case must report an error.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_PASS = 2'd1,
    RES_FAIL = 2'd2,
    RES_ERR  = 2'd3
  } cr_result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_REQ,
    ST_WR_RSP,
    ST_DELAY,
    ST_RD_REQ,
    ST_RD_RSP
  } cr_state_e;
endpackage

// File: rtl/cr_delay_timer.sv
module cr_delay_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              en,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (en && cnt_q != '0)    cnt_q <= cnt_q - WAIT_W'(1);
  end

  assign expired = (cnt_q == '0);

  // R3
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/cr_lane_eval.sv
module cr_lane_eval
  import cr_pkg::*;
#(
  parameter int MAX_LANES = 2,
  localparam int LEN_W = $clog2(MAX_LANES + 1),
  localparam int BUS_W = MAX_LANES * BYTE_W
) (
  input  logic [LEN_W-1:0] lanes,
  input  logic [BUS_W-1:0] status,
  input  logic [BUS_W-1:0] cur_set,
  output logic             all_lock,
  output logic [BUS_W-1:0] new_set,
  output logic             changed
);
  logic [MAX_LANES-1:0] lock_ok;
  logic [MAX_LANES-1:0] unused_hi;

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    localparam logic [LEN_W-1:0] IDX = LEN_W'(l);
    logic act;
    assign act = (IDX < lanes);
    assign lock_ok[l] = !act || status[l*BYTE_W];
    assign new_set[l*BYTE_W +: BYTE_W] = act ?
      {4'b0000, status[l*BYTE_W+3 +: 2], status[l*BYTE_W+1 +: 2]} : '0;
    assign unused_hi[l] = ^status[l*BYTE_W+5 +: 3];
  end

  assign all_lock = &lock_ok;
  assign changed  = (new_set != cur_set);
endmodule

// File: rtl/cr_retry_cnt.sv
module cr_retry_cnt #(
  parameter int SAME_LIMIT = 5,
  parameter int MAX_ITER   = 80,
  localparam int SAME_W = $clog2(SAME_LIMIT + 1),
  localparam int ITER_W = $clog2(MAX_ITER + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic adv,
  input  logic changed,
  output logic at_limit,
  output logic full
);
  logic [SAME_W-1:0] same_q;
  logic [ITER_W-1:0] iter_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      same_q <= SAME_W'(1);
      iter_q <= '0;
    end else if (init) begin
      same_q <= SAME_W'(1);
      iter_q <= '0;
    end else if (adv) begin
      same_q <= changed ? SAME_W'(1) : same_q + SAME_W'(1);
      iter_q <= iter_q + ITER_W'(1);
    end
  end

  assign at_limit = (same_q == SAME_W'(SAME_LIMIT));
  assign full     = (iter_q == ITER_W'(MAX_ITER));

  // R6
  same_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same_q >= SAME_W'(1)) && (same_q <= SAME_W'(SAME_LIMIT)));
  // R6
  adv_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !at_limit);
  // R7
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= ITER_W'(MAX_ITER));
endmodule

// File: rtl/cr_train_ctrl.sv
module cr_train_ctrl
  import cr_pkg::*;
#(
  parameter int         MAX_LANES  = 2,
  parameter int         WAIT_W     = 16,
  parameter int         MAX_ITER   = 80,
  parameter int         SAME_LIMIT = 5,
  parameter logic [7:0] INIT_DRIVE = 8'h02,
  localparam int LEN_W = $clog2(MAX_LANES + 1),
  localparam int BUS_W = MAX_LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  lane_cnt,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [LEN_W-1:0]  req_len,
  output logic [BUS_W-1:0]  req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [LEN_W-1:0]  rsp_len,
  input  logic [BUS_W-1:0]  rsp_data,
  output logic              done,
  output logic [1:0]        result
);
  localparam logic [LEN_W-1:0] RD_LEN = LEN_W'(MAX_LANES);

  cr_state_e        state_q;
  logic [LEN_W-1:0] lanes_q;
  logic [BUS_W-1:0] set_q, init_set, new_set;
  logic             all_lock, changed;
  logic             tmr_load, tmr_exp;
  logic             cnt_init, cnt_adv, same_limit, iter_full;
  logic             fin;
  cr_result_e       fin_res;
  logic             done_q;
  cr_result_e       res_q;

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_init
    localparam logic [LEN_W-1:0] IDX = LEN_W'(l);
    assign init_set[l*BYTE_W +: BYTE_W] = (IDX < lane_cnt) ? INIT_DRIVE : '0;
  end

  cr_lane_eval #(.MAX_LANES(MAX_LANES)) u_eval (
    .lanes(lanes_q), .status(rsp_data), .cur_set(set_q),
    .all_lock(all_lock), .new_set(new_set), .changed(changed)
  );

  cr_delay_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(wait_cycles),
    .en(state_q == ST_DELAY), .expired(tmr_exp)
  );

  cr_retry_cnt #(.SAME_LIMIT(SAME_LIMIT), .MAX_ITER(MAX_ITER)) u_retry (
    .clk(clk), .rst_n(rst_n), .init(cnt_init), .adv(cnt_adv),
    .changed(changed), .at_limit(same_limit), .full(iter_full)
  );

  // Outcome of the current cycle: lock is judged before the retry limits.
  always_comb begin
    tmr_load = 1'b0;
    cnt_init = 1'b0;
    cnt_adv  = 1'b0;
    fin      = 1'b0;
    fin_res  = RES_NONE;
    case (state_q)
      ST_IDLE: cnt_init = start;
      ST_WR_RSP:
        if (rsp_valid) begin
          if (rsp_len != lanes_q) begin fin = 1'b1; fin_res = RES_ERR;  end
          else if (iter_full)     begin fin = 1'b1; fin_res = RES_FAIL; end
          else                    tmr_load = 1'b1;
        end
      ST_RD_RSP:
        if (rsp_valid) begin
          if (rsp_len != RD_LEN)  begin fin = 1'b1; fin_res = RES_ERR;  end
          else if (all_lock)      begin fin = 1'b1; fin_res = RES_PASS; end
          else if (same_limit)    begin fin = 1'b1; fin_res = RES_FAIL; end
          else                    cnt_adv = 1'b1;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lanes_q <= '0;
      set_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      done_q <= fin;
      res_q  <= fin ? fin_res : RES_NONE;
      case (state_q)
        ST_IDLE:
          if (start) begin
            lanes_q <= lane_cnt;
            set_q   <= init_set;
            state_q <= ST_WR_REQ;
          end
        ST_WR_REQ: if (req_ready) state_q <= ST_WR_RSP;
        ST_WR_RSP: if (rsp_valid) state_q <= fin ? ST_IDLE : ST_DELAY;
        ST_DELAY:  if (tmr_exp)   state_q <= ST_RD_REQ;
        ST_RD_REQ: if (req_ready) state_q <= ST_RD_RSP;
        ST_RD_RSP:
          if (rsp_valid) begin
            if (fin) state_q <= ST_IDLE;
            else begin
              set_q   <= new_set;
              state_q <= ST_WR_REQ;
            end
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == ST_WR_REQ) || (state_q == ST_RD_REQ);
  assign req_write = (state_q == ST_WR_REQ);
  assign req_len   = (state_q == ST_WR_REQ) ? lanes_q : RD_LEN;
  assign req_data  = (state_q == ST_WR_REQ) ? set_q : '0;
  assign rsp_ready = (state_q == ST_WR_RSP) || (state_q == ST_RD_RSP);
  assign done      = done_q;
  assign result    = res_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
                                   $stable(req_len) && $stable(req_data)));
  // R10
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done == (result != 2'd0));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd3) |-> (!req_valid && !rsp_ready));
endmodule

// File: tb/cr_train_ctrl_tb_top.sv
module cr_train_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, req_ready, rsp_valid;
  logic [1:0]  lane_cnt, rsp_len, req_len, result;
  logic [15:0] wait_cycles, req_data, rsp_data;
  logic        req_valid, req_write, rsp_ready, done;

  int checks = 0;
  int errors = 0;
  bit done_exp = 1'b0;
  int cyc = 0;

  cr_train_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
    .wait_cycles(wait_cycles), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
    .rsp_data(rsp_data), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // One clock of the per-cycle model comparison.
  task automatic tick();
    @(negedge clk);
    chk(!(req_valid && rsp_ready), "R10 channels exclusive", int'(rsp_ready), 0);
    if (!done_exp) chk(done == 1'b0, "R9 no stray done", int'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R9 watchdog: done actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] stat(input int mode, input int k);
    logic [7:0] b;
    case (mode)
      0: return 16'h0101;
      1: begin
           b = 8'h08 | 8'(((k + 1) & 3) << 1);
           return (k >= 2) ? 16'h0101 : {b, b};
         end
      2: return 16'h0001;
      3: return 16'h0404;
      4: return (k == 4) ? 16'h0505 : 16'h0404;
      5: return ((k % 2) == 0) ? 16'h0A0A : 16'h0404;
      7: return (k < 2) ? 16'h0404 : 16'h0A0A;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic serve(input bit exp_wr, input int exp_len, input logic [15:0] exp_data,
                       input int exp_idle, input int resp_len, input logic [15:0] resp_data,
                       input bit stall, input bit final_, input int exp_res, input string rq);
    int idle = 0;
    while (!req_valid && idle < 5000) begin
      idle++;
      tick();
    end
    chk(idle == exp_idle, "R3 idle cycles before request", idle, exp_idle);
    chk(req_write == exp_wr, "R2 R3 request kind", int'(req_write), int'(exp_wr));
    chk(int'(req_len) == exp_len, "R2 R3 request length", int'(req_len), exp_len);
    if (exp_wr) chk(req_data == exp_data, "R2 R5 drive bytes", int'(req_data), int'(exp_data));
    if (stall) begin
      tick();
      chk(req_valid && req_data == exp_data || (!exp_wr && req_valid),
          "R10 request held under back-pressure", int'(req_valid), 1);
    end
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    chk(rsp_ready == 1'b1, "R10 response awaited", int'(rsp_ready), 1);
    rsp_valid = 1'b1;
    rsp_len   = 2'(resp_len);
    rsp_data  = resp_data;
    done_exp  = final_;
    tick();
    rsp_valid = 1'b0;
    rsp_data  = 16'h0;
    if (final_) begin
      chk(done == 1'b1, "R9 done pulse", int'(done), 1);
      chk(int'(result) == exp_res, rq, int'(result), exp_res);
      chk(req_valid == 1'b0, "R8 no request after verdict", int'(req_valid), 0);
      done_exp = 1'b0;
      tick();
      chk(int'(result) == 0, "R9 result cleared", int'(result), 0);
    end
  endtask

  task automatic run(input int lanes, input int w, input int mode,
                     input int short_rd, input int short_wr, input bit stall);
    logic [15:0] set, nset, st;
    int same = 1;
    int iter = 0;
    int k = 0;
    int nwr = 0;
    int res;
    bit fin;
    bit lockall;
    lane_cnt    = 2'(lanes);
    wait_cycles = 16'(w);
    set = '0;
    for (int l = 0; l < lanes; l++) set[l*8 +: 8] = 8'h02;
    start = 1'b1;
    tick();
    start = 1'b0;
    fin = (short_wr == 0);
    serve(1'b1, lanes, set, 0, fin ? lanes - 1 : lanes, 16'h0, stall, fin, 3,
          "R2 R8 initial write");
    nwr = 1;
    while (!fin) begin
      st = stat(mode, k);
      lockall = 1'b1;
      for (int l = 0; l < lanes; l++) if (!st[l*8]) lockall = 1'b0;
      res = 0;
      if (k == short_rd)   res = 3;
      else if (lockall)    res = 1;
      else if (same == 5)  res = 2;
      fin = (res != 0);
      serve(1'b0, 2, 16'h0, w + 1, (k == short_rd) ? 1 : 2, st, stall, fin, res,
            "R4 R6 R8 read verdict");
      k++;
      if (!fin) begin
        nset = '0;
        for (int l = 0; l < lanes; l++)
          nset[l*8 +: 8] = {4'b0000, st[l*8+3 +: 2], st[l*8+1 +: 2]};
        same = (nset != set) ? 1 : same + 1;
        set  = nset;
        iter++;
        res = (nwr == short_wr) ? 3 : ((iter == 80) ? 2 : 0);
        fin = (res != 0);
        serve(1'b1, lanes, set, 0, (nwr == short_wr) ? lanes - 1 : lanes, 16'h0,
              stall, fin, res, "R5 R7 R8 adjust write");
        nwr++;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
    rsp_len = '0; rsp_data = '0; lane_cnt = 2'd2; wait_cycles = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(done == 1'b0,      "R1 done after reset",      int'(done), 0);
    chk(result == 2'd0,    "R1 result after reset",    int'(result), 0);
    chk(req_valid == 1'b0, "R1 req_valid after reset", int'(req_valid), 0);
    chk(rsp_ready == 1'b0, "R1 rsp_ready after reset", int'(rsp_ready), 0);

    run(2, 3, 0, -1, -1, 1'b0);  // R4 lock on first read
    run(2, 2, 1, -1, -1, 1'b1);  // R5 adjust then lock, with back-pressure
    run(1, 1, 2, -1, -1, 1'b0);  // R4 inactive lane lock ignored
    run(2, 0, 2, -1, -1, 1'b0);  // R6 active lane unlocked, counter runs out
    run(2, 4, 3, -1, -1, 1'b1);  // R6 unchanged requests fail on fifth read
    run(2, 1, 4, -1, -1, 1'b0);  // R6 lock wins at counter limit
    run(2, 1, 7, -1, -1, 1'b0);  // R6 change resets the counter
    run(1, 0, 5, -1, -1, 1'b0);  // R7 iteration cap
    run(2, 2, 3, 2, -1, 1'b0);   // R8 short status read
    run(2, 1, 3, -1, 0, 1'b0);   // R8 short initial write
    run(1, 1, 3, -1, 3, 1'b1);   // R8 short adjust write

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule